// File: doc/BRIEF.md
# I2C Slave Address-Match Transceiver

This block is the slave side of an I2C bus port. It watches the sampled SCL and SDA lines, spots START, repeated START and STOP, and compares the first byte of each transfer with a programmable own address. In 7-bit mode it matches one byte. In 10-bit mode it matches a header byte and then a second byte. On a match it pulls SDA low in the acknowledge slot and raises an addressed flag. The read/write bit then makes it either a byte receiver or a byte transmitter.

Data moves through a shift register and two holding registers, one for each direction. A received byte is copied into the receive holding register at the end of the word. A transmit byte is copied from the transmit holding register when the word starts. When the host has not serviced the holding register in time, the block holds SCL low (clock stretching) until it does. The host can arm a one-shot NACK so that the next received byte is refused. The block drives the bus only through two open-drain pull-down enables. It never generates SCL; it only stretches it.

Top module: `i2cs_slave`

## Requirements
- R1: After reset, scl_pd_o, sda_pd_o, addressed_o, xmit_o, stop_seen_o and rx_full_o are 0, and tx_empty_o is 1.
- R2: In 7-bit mode (addr10_i = 0), the first byte after a START is compared as bits[7:1] against own_addr_i[6:0], with bit 0 taken as the R/W bit. On a match, SDA is held low during the ninth clock and addressed_o is set. On a mismatch, SDA stays released for that byte and for every later byte until the next START.
- R3: A match with R/W = 1 sets xmit_o. Bytes are then taken from the transmit holding register and driven out MSB first, one bit per SCL low phase.
- R4: As receiver, each byte is shifted in MSB first on SCL rising edges. At word end it is copied to rx_data_o, rx_full_o is set and the byte is acknowledged. A one-cycle rx_rd_i pulse clears rx_full_o.
- R5: If a received word completes while rx_full_o is 1, SCL is held low and rx_data_o keeps the old byte. Once rx_rd_i is pulsed, the new byte is copied, acknowledged and SCL is released.
- R6: As transmitter, if the transmit holding register is empty when a word must start, SCL is held low until tx_wr_i is pulsed. tx_empty_o goes to 1 each time a byte is taken and to 0 on tx_wr_i.
- R7: A nack_next_i pulse given before the eighth SCL falling edge of a received data byte makes the block leave SDA released in that byte's acknowledge slot. The byte is still copied to rx_data_o, and later bytes are not acknowledged until the next START.
- R8: A STOP (SDA rising while SCL is high) sets stop_seen_o and clears addressed_o and xmit_o. The next START clears stop_seen_o.
- R9: In 10-bit mode (addr10_i = 1), a first byte of 11110, own_addr_i[9:8], 0 is acknowledged without setting addressed_o. A second byte equal to own_addr_i[7:0] is acknowledged and sets addressed_o. Any other second byte is not acknowledged.
- R10: After a complete 10-bit match, a repeated START followed by 11110, own_addr_i[9:8], 1 is acknowledged, sets addressed_o and enters transmitter mode.
- R11: As transmitter, a NACK from the master in the acknowledge slot ends the transmission. SDA stays released until STOP or START, and the transmit holding register is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pd_o | output | 1 | Pull SCL low (clock stretch) |
| sda_pd_o | output | 1 | Pull SDA low (acknowledge or data 0) |
| own_addr_i | input | 10 | Own slave address; low 7 bits used in 7-bit mode |
| addr10_i | input | 1 | 1 selects 10-bit address matching |
| tx_data_i | input | 8 | Byte for the transmit holding register |
| tx_wr_i | input | 1 | Write strobe for tx_data_i |
| tx_empty_o | output | 1 | Transmit holding register needs a byte |
| rx_data_o | output | 8 | Receive holding register |
| rx_rd_i | input | 1 | Read strobe, releases the receive holding register |
| rx_full_o | output | 1 | Receive holding register holds an unread byte |
| nack_next_i | input | 1 | Arm a NACK for the next received data byte |
| addressed_o | output | 1 | Addressed as slave in the current transfer |
| xmit_o | output | 1 | Slave-transmitter mode |
| stop_seen_o | output | 1 | STOP seen since the last START |

## Verification
The bench builds the block with the default two-stage line synchronizer and a bus master whose SCL half phase is ten block clocks. At these settings the synchronizer and edge-detect latency fits well inside one low phase, so acknowledge and data edges are reached with realistic margins. The long master pauses in the low phase bring both stretch paths within reach, as do the 7-bit and 10-bit matches, repeated-START reads, master NACK and the armed NACK. A seeded random mix of addresses, directions and byte counts runs alongside the directed cases.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0] HDR10 = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_RXHOLD, ST_TXHOLD, ST_TX, ST_TXACK, ST_IGNORE
  } state_e;

  typedef enum logic [1:0] {K_ADR1, K_ADR2, K_DATA} kind_e;
endpackage

// File: rtl/i2cs_line_cond.sv
module i2cs_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  assign scl_s_o = scl_pipe[SYNC_STAGES-1];
  assign sda_s_o = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s_o;
      sda_d <= sda_s_o;
    end
  end

  assign scl_rise_o = scl_s_o & ~scl_d;
  assign scl_fall_o = ~scl_s_o & scl_d;
  assign start_o    = scl_s_o & scl_d & sda_d & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_d & ~sda_d & sda_s_o;

  p_cond_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o) && !(start_o && scl_fall_o));
endmodule

// File: rtl/i2cs_hold_regs.sv
module i2cs_hold_regs
  import i2cs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_wr_i,
  input  logic              tx_take_i,
  output logic [BYTE_W-1:0] tx_hold_o,
  output logic              tx_empty_o,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_load_i,
  input  logic              rx_rd_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_hold_o  <= '0;
      tx_empty_o <= 1'b1;
    end else if (tx_wr_i) begin
      tx_hold_o  <= tx_data_i;
      tx_empty_o <= 1'b0;
    end else if (tx_take_i) begin
      tx_empty_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o <= '0;
      rx_full_o <= 1'b0;
    end else if (rx_load_i) begin
      rx_data_o <= rx_byte_i;
      rx_full_o <= 1'b1;
    end else if (rx_rd_i) begin
      rx_full_o <= 1'b0;
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_load_i |-> !rx_full_o);
  p_take_filled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take_i |-> !tx_empty_o);
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              addr10_i,
  input  logic              nack_next_i,
  input  logic              rx_full_i,
  input  logic              tx_empty_i,
  input  logic [BYTE_W-1:0] tx_hold_i,
  output logic              rx_load_o,
  output logic              tx_take_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              sda_pd_o,
  output logic              scl_pd_o,
  output logic              addressed_o,
  output logic              stop_seen_o,
  output logic              xmit_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  state_e state_q;
  kind_e  kind_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic nack_arm_q, ten_ok_q, mack_q;
  logic evt_ok, word_end, hdr_match, a7_match;

  always_comb begin
    evt_ok    = !start_i && !stop_i;
    word_end  = (state_q == ST_RX) && scl_fall_i && (cnt_q == LAST);
    hdr_match = sh_q[7:1] == {HDR10, own_addr_i[9:8]};
    a7_match  = sh_q[7:1] == own_addr_i[6:0];
    rx_load_o = evt_ok && !rx_full_i &&
                ((word_end && kind_q == K_DATA) || state_q == ST_RXHOLD);
    tx_take_o = evt_ok && !tx_empty_i &&
                ((state_q == ST_ACK && xmit_o && scl_fall_i) ||
                 (state_q == ST_TXACK && mack_q && scl_fall_i) ||
                 state_q == ST_TXHOLD);
  end

  assign rx_byte_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      kind_q      <= K_ADR1;
      cnt_q       <= '0;
      sh_q        <= '0;
      sda_pd_o    <= 1'b0;
      scl_pd_o    <= 1'b0;
      addressed_o <= 1'b0;
      stop_seen_o <= 1'b0;
      xmit_o      <= 1'b0;
      nack_arm_q  <= 1'b0;
      ten_ok_q    <= 1'b0;
      mack_q      <= 1'b0;
    end else begin
      if (nack_next_i) nack_arm_q <= 1'b1;
      if (stop_i) begin
        state_q     <= ST_IDLE;
        sda_pd_o    <= 1'b0;
        scl_pd_o    <= 1'b0;
        addressed_o <= 1'b0;
        xmit_o      <= 1'b0;
        stop_seen_o <= 1'b1;
        ten_ok_q    <= 1'b0;
        nack_arm_q  <= 1'b0;
      end else if (start_i) begin
        state_q     <= ST_RX;
        kind_q      <= K_ADR1;
        cnt_q       <= '0;
        sda_pd_o    <= 1'b0;
        scl_pd_o    <= 1'b0;
        addressed_o <= 1'b0;
        xmit_o      <= 1'b0;
        stop_seen_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i && cnt_q != LAST) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (word_end) begin
              unique case (kind_q)
                K_ADR1: begin
                  if (!addr10_i) begin
                    if (a7_match) begin
                      sda_pd_o    <= 1'b1;
                      state_q     <= ST_ACK;
                      addressed_o <= 1'b1;
                      xmit_o      <= sh_q[0];
                      kind_q      <= K_DATA;
                    end else begin
                      state_q <= ST_IGNORE;
                    end
                  end else if (hdr_match && !sh_q[0]) begin
                    sda_pd_o <= 1'b1;
                    state_q  <= ST_ACK;
                    kind_q   <= K_ADR2;
                    ten_ok_q <= 1'b0;
                  end else if (hdr_match && ten_ok_q) begin
                    sda_pd_o    <= 1'b1;
                    state_q     <= ST_ACK;
                    addressed_o <= 1'b1;
                    xmit_o      <= 1'b1;
                    kind_q      <= K_DATA;
                  end else begin
                    state_q <= ST_IGNORE;
                  end
                end
                K_ADR2: begin
                  if (sh_q == own_addr_i[7:0]) begin
                    sda_pd_o    <= 1'b1;
                    state_q     <= ST_ACK;
                    addressed_o <= 1'b1;
                    ten_ok_q    <= 1'b1;
                    kind_q      <= K_DATA;
                  end else begin
                    state_q <= ST_IGNORE;
                  end
                end
                default: begin
                  if (rx_full_i) begin
                    state_q  <= ST_RXHOLD;
                    scl_pd_o <= 1'b1;
                  end else if (nack_arm_q) begin
                    nack_arm_q <= 1'b0;
                    state_q    <= ST_IGNORE;
                  end else begin
                    sda_pd_o <= 1'b1;
                    state_q  <= ST_ACK;
                  end
                end
              endcase
            end
          end
          ST_RXHOLD: begin
            if (rx_load_o) begin
              scl_pd_o <= 1'b0;
              if (nack_arm_q) begin
                nack_arm_q <= 1'b0;
                state_q    <= ST_IGNORE;
              end else begin
                sda_pd_o <= 1'b1;
                state_q  <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              sda_pd_o <= 1'b0;
              if (!xmit_o) begin
                state_q <= ST_RX;
                cnt_q   <= '0;
              end else if (tx_take_o) begin
                sh_q     <= tx_hold_i;
                sda_pd_o <= ~tx_hold_i[BYTE_W-1];
                cnt_q    <= CNT_W'(1);
                state_q  <= ST_TX;
              end else begin
                state_q  <= ST_TXHOLD;
                scl_pd_o <= 1'b1;
              end
            end
          end
          ST_TXHOLD: begin
            if (tx_take_o) begin
              scl_pd_o <= 1'b0;
              sh_q     <= tx_hold_i;
              sda_pd_o <= ~tx_hold_i[BYTE_W-1];
              cnt_q    <= CNT_W'(1);
              state_q  <= ST_TX;
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == LAST) begin
                sda_pd_o <= 1'b0;
                state_q  <= ST_TXACK;
              end else begin
                sda_pd_o <= ~sh_q[BYTE_W-2];
                sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
                cnt_q    <= cnt_q + CNT_W'(1);
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (!mack_q) begin
                state_q <= ST_IGNORE;
              end else if (tx_take_o) begin
                sh_q     <= tx_hold_i;
                sda_pd_o <= ~tx_hold_i[BYTE_W-1];
                cnt_q    <= CNT_W'(1);
                state_q  <= ST_TX;
              end else begin
                state_q  <= ST_TXHOLD;
                scl_pd_o <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // SDA may only move while SCL is low
  p_sda_scl_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pd_o) |-> !scl_s_i);
  p_ack_on_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addressed_o) |-> sda_pd_o);
  p_stretch_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pd_o |-> !scl_s_i);
  p_stop_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (stop_seen_o && !addressed_o && !xmit_o));
  p_nack_armed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_load_o && nack_arm_q && !nack_next_i) |=> !sda_pd_o);
endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pd_o,
  output logic              sda_pd_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              addr10_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_wr_i,
  output logic              tx_empty_o,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic              rx_rd_i,
  output logic              rx_full_o,
  input  logic              nack_next_i,
  output logic              addressed_o,
  output logic              xmit_o,
  output logic              stop_seen_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic rx_load, tx_take;
  logic [BYTE_W-1:0] rx_byte, tx_hold;

  i2cs_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2cs_hold_regs u_hold (
    .clk_i, .rst_ni,
    .tx_data_i, .tx_wr_i, .tx_take_i(tx_take),
    .tx_hold_o(tx_hold), .tx_empty_o,
    .rx_byte_i(rx_byte), .rx_load_i(rx_load), .rx_rd_i,
    .rx_data_o, .rx_full_o
  );

  i2cs_engine u_eng (
    .clk_i, .rst_ni,
    .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .own_addr_i, .addr10_i, .nack_next_i,
    .rx_full_i(rx_full_o), .tx_empty_i(tx_empty_o), .tx_hold_i(tx_hold),
    .rx_load_o(rx_load), .tx_take_o(tx_take), .rx_byte_o(rx_byte),
    .sda_pd_o, .scl_pd_o, .addressed_o, .stop_seen_o, .xmit_o
  );
endmodule

// File: tb/tb_i2cs_slave.sv
module tb_i2cs_slave;
  localparam int H = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl_m, sda_m, scl_bus, sda_bus;
  logic scl_pd, sda_pd, addr10, tx_wr, rx_rd, nack_next;
  logic tx_empty, rx_full, addressed, xmit, stop_seen;
  logic [9:0] own;
  logic [7:0] tx_data, rx_data;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  assign scl_bus = scl_m & ~scl_pd;
  assign sda_bus = sda_m & ~sda_pd;

  i2cs_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_pd_o(scl_pd), .sda_pd_o(sda_pd), .own_addr_i(own), .addr10_i(addr10),
    .tx_data_i(tx_data), .tx_wr_i(tx_wr), .tx_empty_o(tx_empty),
    .rx_data_o(rx_data), .rx_rd_i(rx_rd), .rx_full_o(rx_full),
    .nack_next_i(nack_next), .addressed_o(addressed), .xmit_o(xmit),
    .stop_seen_o(stop_seen)
  );

  function automatic logic [7:0] f_a7(logic [9:0] a, logic rw);
    return {a[6:0], rw};
  endfunction
  function automatic logic [7:0] f_hdr(logic [9:0] a, logic rw);
    return {5'b11110, a[9:8], rw};
  endfunction

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_scl_high();
    int g = 0;
    while (!scl_bus && g < 20000) begin wt(1); g++; end
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; wt(H);
    scl_m = 1'b1; wait_scl_high(); wt(H);
    r = sda_bus;
    scl_m = 1'b0; wt(H);
  endtask

  task automatic m_start();
    sda_m = 1'b1; wt(2);
    scl_m = 1'b1; wait_scl_high(); wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wait_scl_high(); wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack_n);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, ack_n);
  endtask

  task automatic m_rbyte(input logic nack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, r); d[i] = r; end
    m_bit(nack, r);
  endtask

  task automatic h_wr(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1; wt(1); tx_wr = 1'b0;
  endtask
  task automatic h_rd();
    rx_rd = 1'b1; wt(1); rx_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d, b1, b2, got;
    int seed;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    addr10 = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0; nack_next = 1'b0;
    tx_data = '0; own = 10'h05A;
    wt(5); rst_n = 1'b1; wt(3);

    chk("R1 scl_pd", scl_pd, 0);
    chk("R1 sda_pd", sda_pd, 0);
    chk("R1 addressed", addressed, 0);
    chk("R1 xmit", xmit, 0);
    chk("R1 stop_seen", stop_seen, 0);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 tx_empty", tx_empty, 1);

    // 7-bit write
    own = 10'($urandom % 128);
    m_start();
    m_wbyte(f_a7(own, 1'b0), a);
    chk("R2 ack on match", a, 0);
    chk("R2 addressed", addressed, 1);
    chk("R3 xmit on write", xmit, 0);
    for (int k = 0; k < 4; k++) begin
      d = 8'($urandom);
      m_wbyte(d, a);
      chk("R4 data ack", a, 0);
      chk("R4 rx_data", rx_data, d);
      chk("R4 rx_full set", rx_full, 1);
      h_rd(); wt(1);
      chk("R4 rx_full cleared", rx_full, 0);
    end
    m_stop(); wt(4);
    chk("R8 stop_seen", stop_seen, 1);
    chk("R8 addressed cleared", addressed, 0);

    // mismatch
    m_start();
    chk("R8 start clears stop_seen", stop_seen, 0);
    m_wbyte(f_a7(own ^ 10'h004, 1'b0), a);
    chk("R2 mismatch nack", a, 1);
    chk("R2 mismatch not addressed", addressed, 0);
    m_wbyte(8'h00, a);
    chk("R2 later byte ignored", a, 1);
    chk("R2 later byte not stored", rx_full, 0);
    m_stop();

    // receive stretch
    b1 = 8'hC3; b2 = 8'h3C;
    m_start();
    m_wbyte(f_a7(own, 1'b0), a);
    m_wbyte(b1, a);
    chk("R4 first byte ack", a, 0);
    for (int i = 7; i >= 0; i--) m_bit(b2[i], a);
    wt(30);
    chk("R5 scl held", scl_pd, 1);
    chk("R5 old byte kept", rx_data, b1);
    h_rd(); wt(3);
    chk("R5 scl released", scl_pd, 0);
    m_bit(1'b1, a);
    chk("R5 ack after read", a, 0);
    chk("R5 new byte", rx_data, b2);
    h_rd();
    m_stop();

    // armed nack
    m_start();
    m_wbyte(f_a7(own, 1'b0), a);
    nack_next = 1'b1; wt(1); nack_next = 1'b0;
    m_wbyte(8'hA5, a);
    chk("R7 nack answered", a, 1);
    chk("R7 byte stored", rx_data, 8'hA5);
    h_rd();
    m_wbyte(8'h11, a);
    chk("R7 next ignored", a, 1);
    chk("R7 next not stored", rx_full, 0);
    m_stop();

    // transmit
    h_wr(8'h96);
    m_start();
    m_wbyte(f_a7(own, 1'b1), a);
    chk("R3 read ack", a, 0);
    chk("R3 xmit", xmit, 1);
    m_rbyte(1'b0, got);
    chk("R3 byte out msb first", got, 8'h96);
    chk("R6 tx_empty after take", tx_empty, 1);
    wt(30);
    chk("R6 scl held", scl_pd, 1);
    h_wr(8'h4B); wt(3);
    chk("R6 scl released", scl_pd, 0);
    m_rbyte(1'b1, got);
    chk("R6 byte after refill", got, 8'h4B);
    h_wr(8'hE1);
    m_rbyte(1'b1, got);
    chk("R11 released after master nack", got, 8'hFF);
    chk("R11 holding not consumed", tx_empty, 0);
    m_stop(); wt(4);
    chk("R8 xmit cleared", xmit, 0);

    // 10-bit
    addr10 = 1'b1;
    own = 10'($urandom % 1024);
    m_start();
    m_wbyte(f_hdr(own, 1'b0), a);
    chk("R9 header ack", a, 0);
    chk("R9 not yet addressed", addressed, 0);
    m_wbyte(own[7:0], a);
    chk("R9 low byte ack", a, 0);
    chk("R9 addressed", addressed, 1);
    d = 8'($urandom);
    m_wbyte(d, a);
    chk("R9 data ack", a, 0);
    chk("R9 data stored", rx_data, d);
    h_rd();
    m_start();
    m_wbyte(f_hdr(own, 1'b1), a);
    chk("R10 read header ack", a, 0);
    chk("R10 addressed", addressed, 1);
    chk("R10 xmit", xmit, 1);
    m_rbyte(1'b1, got);
    chk("R10 byte out", got, 8'hE1);
    m_stop();

    m_start();
    m_wbyte(f_hdr(own, 1'b0), a);
    m_wbyte(own[7:0] ^ 8'h01, a);
    chk("R9 wrong low byte nack", a, 1);
    chk("R9 wrong low not addressed", addressed, 0);
    m_stop();

    // random mix, 7-bit
    addr10 = 1'b0;
    for (int it = 0; it < 8; it++) begin
      logic rd, mism;
      int n;
      logic [7:0] q [3];
      own  = 10'($urandom % 128);
      rd   = 1'($urandom % 2);
      mism = ($urandom % 4) == 0;
      n    = 1 + int'($urandom % 3);
      for (int k = 0; k < 3; k++) q[k] = 8'($urandom);
      if (rd) h_wr(q[0]);
      m_start();
      m_wbyte(mism ? f_a7(own ^ 10'(1 << ($urandom % 7)), rd) : f_a7(own, rd), a);
      chk("R2 random address ack", a, mism ? 1 : 0);
      if (!mism) begin
        for (int k = 0; k < n; k++) begin
          if (rd) begin
            m_rbyte(k == n - 1, got);
            chk("R3 random read", got, q[k]);
            if (k < n - 1) h_wr(q[k+1]);
          end else begin
            m_wbyte(q[k], a);
            chk("R4 random write ack", a, 0);
            chk("R4 random write data", rx_data, q[k]);
            h_rd();
          end
        end
      end
      m_stop();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule